// File: doc/BRIEF.md
# Strobe-Based Power Rail Sequencer

This block drives the enable requests of a set of power rails in a programmable order. Each rail is given a 2-bit slot code that ties it to one of four strobe events. When the wake input goes high, the block waits a fixed settle time and then fires the four strobes in ascending order. Programmable waits separate the strobes. A rail's request turns on at its strobe. When wake goes low, the block replays the strobes in descending order with the waits mirrored, and each rail's request turns off at its strobe.

Waits are counted on external timebase pulses. The programmable delays count a millisecond tick. The fixed settle time counts a sub-millisecond tick, and its length is a parameter, for example eleven half-millisecond ticks for 5.5 ms. The configuration inputs are captured when a sequence starts, so software may rewrite them while a sequence runs without disturbing it. If wake falls before power-up completes, the sequence is aborted and the rails are brought down from the highest strobe already fired.

Top module: `rail_seq_top`

## Requirements
- R1: After reset, rail_en_o, busy_o and done_o are all low.
- R2: A rail whose slot code (bits [2r+1:2r] of slot_cfg_i) is 00, 01, 10 or 11 is requested at power-up strobe 1, 2, 3 or 4 respectively. Rails that share a code switch in the same clock cycle.
- R3: Power-up timing: after wake_i is seen high in idle, the block counts SETTLE_TICKS pulses of tick_sub_i, then delay 0 pulses of tick_ms_i, and then fires strobe 1. Strobe k+1 follows strobe k after delay k pulses of tick_ms_i. Delay k is held in bits [8k+7:8k] of dly_cfg_i. A delay of 0 fires without waiting. Pulses of tick_ms_i during the settle wait are ignored, and so are pulses of tick_sub_i outside it.
- R4: busy_o is high while a power-up or power-down runs. done_o is high, with every rail requested, once strobe 4 has fired and wake_i stays high. busy_o and done_o are never high together.
- R5: Power-down: when wake_i goes low after done, the strobe 4 rails drop after delay 0 ms ticks. The strobe 3, 2 and 1 rails then drop after delay 3, delay 2 and delay 1 ticks in turn. After that the block is idle.
- R6: A rail request rises only while wake_i is high. Between its strobe and its reverse strobe it does not change, and no request changes while the block is neither busy nor changing state.
- R7: If wake_i falls during power-up after L strobes (L>0), the rails of strobe L drop after delay 0 ticks. The rails of each lower strobe j then drop after delay j ticks. If no strobe has fired yet, the block returns to idle at once. Ticks already counted are discarded.
- R8: wake_i rising during power-down has no effect until every rail is off. A new power-up then starts immediately.
- R9: Slot codes are captured when power-up starts and are held until the block is idle again. Delays are captured at the start of each power-up and each power-down. Changes to the inputs in between have no effect.
- R10: While neither busy_o nor done_o is high, every rail request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | High requests power-up, low requests power-down |
| tick_ms_i | input | 1 | One-cycle millisecond timebase pulse |
| tick_sub_i | input | 1 | One-cycle sub-millisecond timebase pulse for the settle wait |
| slot_cfg_i | input | 2*N_RAILS | Per-rail slot codes, rail r at bits [2r+1:2r] |
| dly_cfg_i | input | 4*DLY_W | Delays 0..3, delay k at bits [DLY_W*k+DLY_W-1:DLY_W*k] |
| rail_en_o | output | N_RAILS | Per-rail enable requests |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Power-up complete, all rails requested |

## Verification
A strobe changes rail_en_o two rising edges after the edge that samples the tick pulse completing its wait. The first edge registers the count and the second fires the strobe. A zero-delay strobe follows the previous strobe, or the wake edge, one edge later. The driver puts the expected request vector into the scoreboard queue just before it gives the completing tick or wake change. It then leaves twelve idle cycles before the next stimulus, so each change falls inside its window. A change that appears with an empty queue is reported as early, and a queue still holding entries at the end of a sequence is reported as a missing or late strobe.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  localparam int unsigned N_SLOTS = 4;
  localparam int unsigned SLOT_W  = 2;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SETTLE,
    ST_UP,
    ST_ON,
    ST_DN
  } seq_state_e;
endpackage

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = (cnt_q == target_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (tick_i && !hit_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rail_seq_map.sv
module rail_seq_map
  import rail_seq_pkg::*;
#(
  parameter int unsigned N_RAILS = 4,
  parameter int unsigned LVL_W   = 3
) (
  input  logic [N_RAILS*SLOT_W-1:0] codes_i,
  input  logic [LVL_W-1:0]          level_i,
  output logic [N_RAILS-1:0]        en_o
);
  // rail is on once the fired-strobe count passes its slot code
  for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
    assign en_o[r] = LVL_W'(codes_i[r*SLOT_W +: SLOT_W]) < level_i;
  end
endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
  import rail_seq_pkg::*;
#(
  parameter int unsigned N_RAILS      = 4,
  parameter int unsigned DLY_W        = 8,
  parameter int unsigned SETTLE_TICKS = 11,
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned LVL_W        = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wake_i,
  input  logic [N_RAILS*SLOT_W-1:0] slot_cfg_i,
  input  logic [N_SLOTS*DLY_W-1:0]  dly_cfg_i,
  input  logic                      hit_i,
  output logic                      tmr_clr_o,
  output logic                      tmr_sub_o,
  output logic [CNT_W-1:0]          tmr_target_o,
  output logic [LVL_W-1:0]          level_o,
  output logic [N_RAILS*SLOT_W-1:0] codes_o,
  output logic                      busy_o,
  output logic                      done_o
);
  localparam int unsigned CODE_W = N_RAILS * SLOT_W;
  localparam int unsigned IDX_W  = $clog2(N_SLOTS);

  seq_state_e                    state_q, state_d;
  logic [LVL_W-1:0]              level_q, level_d;
  logic                          first_q, first_d;
  logic [CODE_W-1:0]             codes_q;
  logic [N_SLOTS-1:0][DLY_W-1:0] dly_q;
  logic                          snap_codes, snap_dly;
  logic [IDX_W-1:0]              dly_idx;
  logic                          last_up, last_dn;

  assign last_up = (level_q == LVL_W'(N_SLOTS - 1));
  assign last_dn = (level_q == LVL_W'(1));

  // first fall step always uses delay 0, later ones mirror the rise delays
  assign dly_idx      = (state_q == ST_DN && first_q) ? '0 : level_q[IDX_W-1:0];
  assign tmr_sub_o    = (state_q == ST_SETTLE);
  assign tmr_target_o = tmr_sub_o ? CNT_W'(SETTLE_TICKS) : CNT_W'(dly_q[dly_idx]);

  always_comb begin
    state_d    = state_q;
    level_d    = level_q;
    first_d    = first_q;
    snap_codes = 1'b0;
    snap_dly   = 1'b0;
    tmr_clr_o  = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        tmr_clr_o = 1'b1;
        if (wake_i) begin
          state_d    = ST_SETTLE;
          snap_codes = 1'b1;
          snap_dly   = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (!wake_i) begin
          state_d   = ST_OFF;
          tmr_clr_o = 1'b1;
        end else if (hit_i) begin
          state_d   = ST_UP;
          tmr_clr_o = 1'b1;
        end
      end
      ST_UP: begin
        if (!wake_i) begin
          tmr_clr_o = 1'b1;
          if (level_q == '0) begin
            state_d = ST_OFF;
          end else begin
            state_d  = ST_DN;
            first_d  = 1'b1;
            snap_dly = 1'b1;
          end
        end else if (hit_i) begin
          tmr_clr_o = 1'b1;
          level_d   = level_q + 1'b1;
          if (last_up) state_d = ST_ON;
        end
      end
      ST_ON: begin
        tmr_clr_o = 1'b1;
        if (!wake_i) begin
          state_d  = ST_DN;
          first_d  = 1'b1;
          snap_dly = 1'b1;
        end
      end
      ST_DN: begin
        if (hit_i) begin
          tmr_clr_o = 1'b1;
          level_d   = level_q - 1'b1;
          first_d   = 1'b0;
          if (last_dn) state_d = ST_OFF;
        end
      end
      default: begin
        state_d   = ST_OFF;
        level_d   = '0;
        tmr_clr_o = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      level_q <= '0;
      first_q <= 1'b0;
      codes_q <= '0;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      level_q <= level_d;
      first_q <= first_d;
      if (snap_codes) codes_q <= slot_cfg_i;
      if (snap_dly)   dly_q   <= dly_cfg_i;
    end
  end

  assign level_o = level_q;
  assign codes_o = codes_q;
  assign busy_o  = (state_q == ST_SETTLE) || (state_q == ST_UP) || (state_q == ST_DN);
  assign done_o  = (state_q == ST_ON);
endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top
  import rail_seq_pkg::*;
#(
  parameter int unsigned N_RAILS      = 4,
  parameter int unsigned DLY_W        = 8,
  parameter int unsigned SETTLE_TICKS = 11
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wake_i,
  input  logic                      tick_ms_i,
  input  logic                      tick_sub_i,
  input  logic [N_RAILS*SLOT_W-1:0] slot_cfg_i,
  input  logic [N_SLOTS*DLY_W-1:0]  dly_cfg_i,
  output logic [N_RAILS-1:0]        rail_en_o,
  output logic                      busy_o,
  output logic                      done_o
);
  localparam int unsigned SET_W = $clog2(SETTLE_TICKS + 1);
  localparam int unsigned CNT_W = (DLY_W > SET_W) ? DLY_W : SET_W;
  localparam int unsigned LVL_W = $clog2(N_SLOTS + 1);

  logic                      tmr_clr, tmr_sub, tmr_hit, tmr_tick;
  logic [CNT_W-1:0]          tmr_target;
  logic [LVL_W-1:0]          level;
  logic [N_RAILS*SLOT_W-1:0] codes;

  assign tmr_tick = tmr_sub ? tick_sub_i : tick_ms_i;

  rail_seq_fsm #(
    .N_RAILS(N_RAILS), .DLY_W(DLY_W), .SETTLE_TICKS(SETTLE_TICKS),
    .CNT_W(CNT_W), .LVL_W(LVL_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wake_i       (wake_i),
    .slot_cfg_i   (slot_cfg_i),
    .dly_cfg_i    (dly_cfg_i),
    .hit_i        (tmr_hit),
    .tmr_clr_o    (tmr_clr),
    .tmr_sub_o    (tmr_sub),
    .tmr_target_o (tmr_target),
    .level_o      (level),
    .codes_o      (codes),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  rail_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .tick_i   (tmr_tick),
    .target_i (tmr_target),
    .hit_o    (tmr_hit)
  );

  rail_seq_map #(.N_RAILS(N_RAILS), .LVL_W(LVL_W)) u_map (
    .codes_i (codes),
    .level_i (level),
    .en_o    (rail_en_o)
  );
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int unsigned N_RAILS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wake_i,
  input logic [N_RAILS-1:0] rail_en_o,
  input logic               busy_o,
  input logic               done_o
);
  assert_busy_done_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_done_all_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (&rail_en_o));

  assert_idle_rails_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o) |-> (rail_en_o == '0));

  assert_rise_needs_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rail_en_o & ~$past(rail_en_o)) != '0) |-> $past(wake_i));

  assert_change_when_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rail_en_o != $past(rail_en_o)) |-> $past(busy_o));

  assert_done_from_seq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(busy_o) && $past(wake_i)));
endmodule

bind rail_seq_top rail_seq_chk #(.N_RAILS(N_RAILS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wake_i    (wake_i),
  .rail_en_o (rail_en_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/tb_rail_seq_top.sv
module tb_rail_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAILS    = 4;
  localparam int DLY_W      = 8;
  localparam int SETTLE     = 11;
  localparam int GAP        = 12;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wake = 1'b0, tick_ms = 1'b0, tick_sub = 1'b0;
  logic [2*N_RAILS-1:0] slot_cfg = '0;
  logic [4*DLY_W-1:0]   dly_cfg = '0;
  logic [N_RAILS-1:0]   rail_en_o;
  logic                 busy_o, done_o;

  int checks = 0, fails = 0;
  logic [N_RAILS-1:0] exp_q[$];
  logic [N_RAILS-1:0] last_exp = '0;

  // stage list: kind (1 = ms, 0 = sub), tick count, has event, event value
  bit                 st_k[$];
  int                 st_n[$];
  bit                 st_h[$];
  logic [N_RAILS-1:0] st_v[$];

  bit                   scr_en = 1'b0;
  logic [2*N_RAILS-1:0] scr_slot;
  logic [4*DLY_W-1:0]   scr_dly;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_seq_top #(.N_RAILS(N_RAILS), .DLY_W(DLY_W), .SETTLE_TICKS(SETTLE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wake_i(wake), .tick_ms_i(tick_ms),
    .tick_sub_i(tick_sub), .slot_cfg_i(slot_cfg), .dly_cfg_i(dly_cfg),
    .rail_en_o(rail_en_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [N_RAILS-1:0] exp_rails(input logic [2*N_RAILS-1:0] c, input int lvl);
    logic [N_RAILS-1:0] v;
    for (int r = 0; r < N_RAILS; r++) v[r] = (int'(c[2*r +: 2]) < lvl);
    return v;
  endfunction

  function automatic logic [4*DLY_W-1:0] pack_dly(input int d0, input int d1, input int d2, input int d3);
    return {DLY_W'(d3), DLY_W'(d2), DLY_W'(d1), DLY_W'(d0)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  function automatic void push_exp(input logic [N_RAILS-1:0] v);
    if (v != last_exp) begin
      exp_q.push_back(v);
      last_exp = v;
    end
  endfunction

  function automatic void add_stage(input bit k, input int n, input bit h, input logic [N_RAILS-1:0] v);
    st_k.push_back(k); st_n.push_back(n); st_h.push_back(h); st_v.push_back(v);
  endfunction

  function automatic void add_up(input logic [2*N_RAILS-1:0] c, input int d[4]);
    add_stage(1'b0, SETTLE, 1'b0, '0);
    for (int l = 0; l < 4; l++) add_stage(1'b1, d[l], 1'b1, exp_rails(c, l + 1));
  endfunction

  function automatic void add_down(input logic [2*N_RAILS-1:0] c, input int d[4], input int from_lvl);
    add_stage(1'b1, d[0], 1'b1, exp_rails(c, from_lvl - 1));
    for (int l = from_lvl - 1; l >= 1; l--) add_stage(1'b1, d[l], 1'b1, exp_rails(c, l - 1));
  endfunction

  task automatic pulse(input bit ms, input bit stray);
    @(negedge clk);
    if (ms) tick_ms = 1'b1; else tick_sub = 1'b1;
    @(negedge clk);
    tick_ms = 1'b0; tick_sub = 1'b0;
    repeat (GAP/2) @(negedge clk);
    if (stray) begin
      // other timebase pulse, must be ignored by the current wait (R3)
      if (ms) tick_sub = 1'b1; else tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0; tick_sub = 1'b0;
    end
    repeat (GAP/2) @(negedge clk);
  endtask

  task automatic push_from(input int j);
    for (int i = j; i < st_n.size(); i++) begin
      if (i > j && st_n[i] != 0) break;
      if (st_h[i]) push_exp(st_v[i]);
    end
  endtask

  task automatic run_seq(input bit wake_val);
    int first = 0;
    while (first < st_n.size() && st_n[first] == 0) begin
      if (st_h[first]) push_exp(st_v[first]);
      first++;
    end
    if (wake !== wake_val) begin
      @(negedge clk);
      wake = wake_val;
      repeat (2) @(negedge clk);
      chk(busy_o === 1'b1, "R4", "busy after wake change", busy_o, 1);
      if (scr_en) begin
        slot_cfg = scr_slot;
        dly_cfg  = scr_dly;
      end
    end
    for (int i = first; i < st_n.size(); i++) begin
      if (st_n[i] == 0) continue;
      for (int t = 0; t < st_n[i] - 1; t++) pulse(st_k[i], 1'b1);
      push_from(i);
      pulse(st_k[i], 1'b0);
    end
    repeat (GAP) @(negedge clk);
    st_k.delete(); st_n.delete(); st_h.delete(); st_v.delete();
    chk(exp_q.size() == 0, "R3", "strobes missing or late", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // scoreboard monitor
  initial begin
    logic [N_RAILS-1:0] prev = '0;
    logic [N_RAILS-1:0] e;
    @(posedge rst_ni);
    forever begin
      @(negedge clk);
      if (rail_en_o !== prev) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R6 unexpected rail change act=%b exp=%b", rail_en_o, prev);
        end else begin
          e = exp_q.pop_front();
          if (rail_en_o !== e) begin
            fails++;
            $display("FAIL R2 R3 rail_en act=%b exp=%b", rail_en_o, e);
          end
        end
        prev = rail_en_o;
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run hung act=%0d exp=%0d", WD_CYCLES, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [2*N_RAILS-1:0] c;
    int d[4];
    int dd[4];

    repeat (3) @(negedge clk);
    chk(rail_en_o === '0, "R1", "rails at reset", int'(rail_en_o), 0);
    chk(busy_o === 1'b0, "R1", "busy at reset", busy_o, 0);
    chk(done_o === 1'b0, "R1", "done at reset", done_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // T1: one rail per slot, R2 R3 R5
    c = {2'b11, 2'b10, 2'b01, 2'b00};
    d = '{2, 1, 3, 1};
    slot_cfg = c; dly_cfg = pack_dly(d[0], d[1], d[2], d[3]);
    add_up(c, d); run_seq(1'b1);
    chk(done_o === 1'b1 && busy_o === 1'b0, "R4", "done after power-up", done_o, 1);
    chk(rail_en_o === 4'hF, "R4", "all rails on", int'(rail_en_o), 15);
    add_down(c, d, 4); run_seq(1'b0);
    chk(!busy_o && !done_o, "R5", "idle after power-down", busy_o, 0);
    chk(rail_en_o === '0, "R10", "rails off when idle", int'(rail_en_o), 0);

    // T2: shared slots, zero delays, config rewritten mid-sequence (R9)
    c = {2'b00, 2'b10, 2'b00, 2'b10};
    d = '{0, 2, 0, 1};
    slot_cfg = c; dly_cfg = pack_dly(d[0], d[1], d[2], d[3]);
    scr_en = 1'b1; scr_slot = {2'b11, 2'b11, 2'b11, 2'b11}; scr_dly = pack_dly(1, 0, 2, 0);
    add_up(c, d); run_seq(1'b1);
    chk(done_o === 1'b1, "R9", "done with captured config", done_o, 1);
    dd = '{1, 0, 2, 0};
    scr_slot = {2'b01, 2'b01, 2'b01, 2'b01}; scr_dly = pack_dly(3, 3, 3, 3);
    add_down(c, dd, 4); run_seq(1'b0);
    scr_en = 1'b0;
    chk(!busy_o && !done_o, "R9", "idle after down with captured delays", busy_o, 0);

    // T3: abort after two strobes (R7)
    c = {2'b11, 2'b10, 2'b01, 2'b00};
    d = '{1, 1, 2, 1};
    slot_cfg = c; dly_cfg = pack_dly(d[0], d[1], d[2], d[3]);
    add_stage(1'b0, SETTLE, 1'b0, '0);
    add_stage(1'b1, d[0], 1'b1, exp_rails(c, 1));
    add_stage(1'b1, d[1], 1'b1, exp_rails(c, 2));
    add_stage(1'b1, 1, 1'b0, '0);
    run_seq(1'b1);
    chk(rail_en_o === exp_rails(c, 2), "R7", "two strobes before abort", int'(rail_en_o), int'(exp_rails(c, 2)));
    add_down(c, d, 2); run_seq(1'b0);
    chk(!busy_o && rail_en_o === '0, "R7", "idle after abort", int'(rail_en_o), 0);

    // T3b: abort during settle, then full restart counts from zero (R7)
    add_stage(1'b0, 3, 1'b0, '0); run_seq(1'b1);
    @(negedge clk); wake = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R7", "settle abort returns idle", busy_o, 0);
    chk(rail_en_o === '0, "R7", "no rail after settle abort", int'(rail_en_o), 0);
    add_up(c, d); run_seq(1'b1);
    chk(done_o === 1'b1, "R7", "restart completes", done_o, 1);
    add_down(c, d, 4); run_seq(1'b0);

    // T4: wake rises during power-down (R8)
    c = {2'b01, 2'b11, 2'b00, 2'b10};
    d = '{1, 2, 1, 2};
    slot_cfg = c; dly_cfg = pack_dly(d[0], d[1], d[2], d[3]);
    add_up(c, d); run_seq(1'b1);
    add_stage(1'b1, d[0], 1'b1, exp_rails(c, 3));
    add_stage(1'b1, d[3], 1'b1, exp_rails(c, 2));
    run_seq(1'b0);
    @(negedge clk); wake = 1'b1;
    repeat (GAP) @(negedge clk);
    chk(busy_o === 1'b1 && rail_en_o === exp_rails(c, 2), "R8", "wake ignored mid power-down",
        int'(rail_en_o), int'(exp_rails(c, 2)));
    add_stage(1'b1, d[2], 1'b1, exp_rails(c, 1));
    add_stage(1'b1, d[1], 1'b1, exp_rails(c, 0));
    add_up(c, d); run_seq(1'b1);
    chk(done_o === 1'b1, "R8", "power-up after power-down", done_o, 1);
    add_down(c, d, 4); run_seq(1'b0);
    chk(!busy_o && !done_o && rail_en_o === '0, "R10", "final idle", int'(rail_en_o), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule